// File: doc/BRIEF.md
# Accumulator CPU with zero flag

This block is a small multicycle 8-bit processor built around one accumulator. It fetches one-byte opcodes over a synchronous byte-wide memory port with a 16-bit address. It executes sixteen instructions:

- data movement between the accumulator, a second-operand register and memory;
- arithmetic and logic on the accumulator;
- absolute jumps, two of which depend on a single zero flag.

Peripherals sit in the same address space and are reached with the same load and store instructions. The accumulator, operand register, zero flag and program counter are brought out for observation.

The memory returns read data one clock after the address is presented. A state machine sequences every instruction and spends one wait state on each read. It has eight states:

- FETCH presents the program counter.
- DECODE captures the opcode. A one-byte instruction executes there and returns to FETCH. An address-carrying opcode goes to ADR_LO_REQ.
- ADR_LO_REQ moves to ADR_LO_CAP, which captures the low address byte.
- ADR_HI_REQ moves to ADR_HI_CAP, which captures the high address byte.
- From ADR_HI_CAP, a jump goes to FETCH. A load or store goes to DATA.
- DATA presents the operand address and writes for a store, then goes to FETCH. For a load it goes to LOAD.
- LOAD captures the byte into the accumulator and goes to FETCH.

Top module: `acc_core`

## Requirements
- R1: While reset is high, the program counter, accumulator, operand register and zero flag are cleared and the write strobe is low. After reset the first opcode is fetched from address 0000h.
- R2: Every opcode is one byte. LDAC 01h, STAC 02h, JUMP 05h, JMPZ 06h and JPNZ 07h are followed by a 16-bit address, low byte first and then high byte. For example, 05h 34h 12h jumps to 1234h.
- R3: Read data is used one clock after its address. Measured from one opcode fetch to the next, a one-byte instruction takes 2 cycles, a jump 6, STAC 7 and LDAC 8.
- R4: LDAC loads the accumulator from the addressed byte. STAC raises the write strobe for exactly one cycle, with the operand address and the accumulator value on the port. Neither instruction changes the zero flag.
- R5: MVAC 03h copies the accumulator into the operand register, and MOVR 04h copies the operand register into the accumulator. Both leave the zero flag unchanged.
- R6: ADD 08h, SUB 09h (accumulator minus operand) and INAC 0Ah wrap modulo 256. Each sets the zero flag to 1 exactly when the 8-bit result is zero, and to 0 otherwise.
- R7: AND 0Ch, OR 0Dh, XOR 0Eh (accumulator with operand) and NOT 0Fh (invert the accumulator) write the accumulator. Each sets the zero flag from the result as in R6.
- R8: CLAC 0Bh clears the accumulator and sets the zero flag.
- R9: JUMP loads the program counter with the address.
- R10: JMPZ branches only when the zero flag is 1, and JPNZ only when it is 0. A branch that is not taken continues at the opcode address plus 3.
- R11: 00h and every opcode from 10h to FFh execute as a one-byte no-op: only the program counter advances, by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Memory byte address |
| mem_rdata | input | 8 | Read data, valid one clock after its address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| dbg_pc | output | 16 | Program counter |
| dbg_ac | output | 8 | Accumulator |
| dbg_r | output | 8 | Operand register |
| dbg_z | output | 1 | Zero flag |

## Verification
The hardest situations to reach from the ports are the ones where the zero flag carries over across instructions that must not touch it. One case is a conditional branch that reads a flag set several instructions earlier, after data movement and loads have run in between. The other is a not-taken branch, which must still step past both address bytes. The stimulus programs set up both cases on purpose:

- An increment wraps FFh to 00h, then a copy and a load run while the flag is still set.
- Each conditional jump is placed in both its taken and its untaken polarity.
- A summing loop exits only through an untaken JPNZ.

A behavioural model checks every cycle against the expected state.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [2:0] {
        S_FETCH,
        S_DECODE,
        S_ADR_LO_REQ,
        S_ADR_LO_CAP,
        S_ADR_HI_REQ,
        S_ADR_HI_CAP,
        S_DATA,
        S_LOAD
    } seq_state_t;

    localparam logic [7:0] OP_NOP  = 8'h00;
    localparam logic [7:0] OP_LDAC = 8'h01;
    localparam logic [7:0] OP_STAC = 8'h02;
    localparam logic [7:0] OP_MVAC = 8'h03;
    localparam logic [7:0] OP_MOVR = 8'h04;
    localparam logic [7:0] OP_JUMP = 8'h05;
    localparam logic [7:0] OP_JMPZ = 8'h06;
    localparam logic [7:0] OP_JPNZ = 8'h07;
    localparam logic [7:0] OP_ADD  = 8'h08;
    localparam logic [7:0] OP_SUB  = 8'h09;
    localparam logic [7:0] OP_INAC = 8'h0A;
    localparam logic [7:0] OP_CLAC = 8'h0B;
    localparam logic [7:0] OP_AND  = 8'h0C;
    localparam logic [7:0] OP_OR   = 8'h0D;
    localparam logic [7:0] OP_XOR  = 8'h0E;
    localparam logic [7:0] OP_NOT  = 8'h0F;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [7:0]    op,
    input  logic [DW-1:0] ac,
    input  logic [DW-1:0] r,
    output logic [DW-1:0] res,
    output logic          res_zero,
    output logic          wr_ac,
    output logic          wr_z,
    output logic          wr_r
);

    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    always_comb begin
        res   = ac;
        wr_ac = 1'b0;
        wr_z  = 1'b0;
        wr_r  = 1'b0;
        unique case (op)
            OP_MVAC: wr_r = 1'b1;
            OP_MOVR: begin res = r;        wr_ac = 1'b1; end
            OP_ADD:  begin res = ac + r;   wr_ac = 1'b1; wr_z = 1'b1; end
            OP_SUB:  begin res = ac - r;   wr_ac = 1'b1; wr_z = 1'b1; end
            OP_INAC: begin res = ac + ONE; wr_ac = 1'b1; wr_z = 1'b1; end
            OP_CLAC: begin res = '0;       wr_ac = 1'b1; wr_z = 1'b1; end
            OP_AND:  begin res = ac & r;   wr_ac = 1'b1; wr_z = 1'b1; end
            OP_OR:   begin res = ac | r;   wr_ac = 1'b1; wr_z = 1'b1; end
            OP_XOR:  begin res = ac ^ r;   wr_ac = 1'b1; wr_z = 1'b1; end
            OP_NOT:  begin res = ~ac;      wr_ac = 1'b1; wr_z = 1'b1; end
            default: ;
        endcase
        res_zero = (res == '0);
    end

endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import acc_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] mem_rdata,
    input  logic          z,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          exec_en,
    output logic          load_en,
    output logic [AW-1:0] pc
);

    localparam logic [AW-1:0] PC_ONE = {{(AW-1){1'b0}}, 1'b1};

    seq_state_t    state, state_nxt;
    logic [7:0]    ir;
    logic [DW-1:0] adr_lo, adr_hi;
    logic          is_addr_op;
    logic          take;

    assign is_addr_op = (mem_rdata[7:0] == OP_LDAC) || (mem_rdata[7:0] == OP_STAC) ||
                        (mem_rdata[7:0] == OP_JUMP) || (mem_rdata[7:0] == OP_JMPZ) ||
                        (mem_rdata[7:0] == OP_JPNZ);

    assign take = (ir == OP_JUMP) || ((ir == OP_JMPZ) && z) || ((ir == OP_JPNZ) && !z);

    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_FETCH:      state_nxt = S_DECODE;
            S_DECODE:     state_nxt = is_addr_op ? S_ADR_LO_REQ : S_FETCH;
            S_ADR_LO_REQ: state_nxt = S_ADR_LO_CAP;
            S_ADR_LO_CAP: state_nxt = S_ADR_HI_REQ;
            S_ADR_HI_REQ: state_nxt = S_ADR_HI_CAP;
            S_ADR_HI_CAP: state_nxt = ((ir == OP_LDAC) || (ir == OP_STAC)) ? S_DATA : S_FETCH;
            S_DATA:       state_nxt = (ir == OP_LDAC) ? S_LOAD : S_FETCH;
            S_LOAD:       state_nxt = S_FETCH;
            default:      state_nxt = S_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            ir     <= '0;
            adr_lo <= '0;
            adr_hi <= '0;
        end else begin
            unique case (state)
                S_DECODE: begin
                    ir <= mem_rdata[7:0];
                    pc <= pc + PC_ONE;
                end
                S_ADR_LO_CAP: begin
                    adr_lo <= mem_rdata;
                    pc     <= pc + PC_ONE;
                end
                S_ADR_HI_CAP: begin
                    adr_hi <= mem_rdata;
                    pc     <= take ? {mem_rdata, adr_lo} : pc + PC_ONE;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_addr = (state == S_DATA) ? {adr_hi, adr_lo} : pc;
        mem_we   = (state == S_DATA) && (ir == OP_STAC);
        exec_en  = (state == S_DECODE) && !is_addr_op;
        load_en  = (state == S_LOAD);
    end

    AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we); // R4

    AST_SHORT_STEP: assert property (@(posedge clk) disable iff (rst)
        exec_en |=> (state == S_FETCH) && (pc == $past(pc) + PC_ONE)); // R3

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (state == S_ADR_HI_CAP) && (ir == OP_JUMP) |=> pc == {$past(mem_rdata), adr_lo}); // R9

    AST_BRANCH_SKIP: assert property (@(posedge clk) disable iff (rst)
        (state == S_ADR_HI_CAP) && (((ir == OP_JMPZ) && !z) || ((ir == OP_JPNZ) && z))
        |=> (pc == $past(pc) + PC_ONE) && (state == S_FETCH)); // R10

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic [AW-1:0] dbg_pc,
    output logic [DW-1:0] dbg_ac,
    output logic [DW-1:0] dbg_r,
    output logic          dbg_z
);

    logic [DW-1:0] ac, r;
    logic          z;
    logic          exec_en, load_en;
    logic [DW-1:0] alu_res;
    logic          alu_zero, alu_wr_ac, alu_wr_z, alu_wr_r;

    acc_seq #(.DW(DW), .AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .z         (z),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .exec_en   (exec_en),
        .load_en   (load_en),
        .pc        (dbg_pc)
    );

    acc_alu #(.DW(DW)) u_alu (
        .op       (mem_rdata[7:0]),
        .ac       (ac),
        .r        (r),
        .res      (alu_res),
        .res_zero (alu_zero),
        .wr_ac    (alu_wr_ac),
        .wr_z     (alu_wr_z),
        .wr_r     (alu_wr_r)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ac <= '0;
            r  <= '0;
            z  <= 1'b0;
        end else if (load_en) begin
            ac <= mem_rdata;
        end else if (exec_en) begin
            if (alu_wr_ac) ac <= alu_res;
            if (alu_wr_z)  z  <= alu_zero;
            if (alu_wr_r)  r  <= ac;
        end
    end

    assign mem_wdata = ac;
    assign dbg_ac    = ac;
    assign dbg_r     = r;
    assign dbg_z     = z;

    AST_CLAC_RESULT: assert property (@(posedge clk) disable iff (rst)
        exec_en && (mem_rdata[7:0] == OP_CLAC) |=> z && (ac == '0)); // R8

    AST_ZFLAG_TRACKS: assert property (@(posedge clk) disable iff (rst)
        exec_en && alu_wr_z |=> z == (ac == '0)); // R6

    AST_MOVE_KEEPS_Z: assert property (@(posedge clk) disable iff (rst)
        exec_en && !alu_wr_z |=> $stable(z)); // R5

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (ac == $past(mem_rdata)) && $stable(z)); // R4

    AST_MVAC_COPY: assert property (@(posedge clk) disable iff (rst)
        exec_en && (mem_rdata[7:0] == OP_MVAC) |=> r == $past(ac)); // R5

endmodule

// File: tb/test_acc_core.sv
module test_acc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [15:0] dbg_pc;
    logic [7:0]  dbg_ac, dbg_r;
    logic        dbg_z;

    logic [7:0]  mem [0:4095];
    int          n_chk = 0;
    int          n_fail = 0;
    int          wp;

    logic [15:0] m_pc;
    logic [7:0]  m_ac, m_r;
    logic        m_z;
    int          m_off, m_len;
    logic [7:0]  m_op;
    logic [15:0] m_wa;
    logic [7:0]  m_wd;
    string       m_req;

    always #5 clk = ~clk;

    acc_core i_acc_core (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .dbg_pc    (dbg_pc),
        .dbg_ac    (dbg_ac),
        .dbg_r     (dbg_r),
        .dbg_z     (dbg_z)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[11:0]];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rd(input logic [15:0] a);
        return mem[a[11:0]];
    endfunction

    task automatic emit(input logic [7:0] b);
        mem[wp] = b;
        wp++;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    endtask

    // Behavioural instruction model, stepped once per clock at the falling edge
    task automatic model_step();
        logic [15:0] tgt;
        if (m_off == 0) begin
            check("R3", {16'h0, mem_addr}, {16'h0, m_pc});
            check(m_req, {16'h0, dbg_pc}, {16'h0, m_pc});
            check(m_req, {24'h0, dbg_ac}, {24'h0, m_ac});
            check(m_req, {24'h0, dbg_r}, {24'h0, m_r});
            check(m_req, {31'h0, dbg_z}, {31'h0, m_z});
            m_op = rd(m_pc);
            tgt  = {rd(m_pc + 16'd2), rd(m_pc + 16'd1)};
            m_len = 2;
            case (m_op)
                8'h01: begin m_ac = rd(tgt); m_len = 8; m_pc = m_pc + 16'd3; m_req = "R4"; end
                8'h02: begin m_wa = tgt; m_wd = m_ac; m_len = 7; m_pc = m_pc + 16'd3; m_req = "R4"; end
                8'h03: begin m_r = m_ac; m_pc = m_pc + 16'd1; m_req = "R5"; end
                8'h04: begin m_ac = m_r; m_pc = m_pc + 16'd1; m_req = "R5"; end
                8'h05: begin m_pc = tgt; m_len = 6; m_req = "R9 R2"; end
                8'h06: begin m_pc = m_z ? tgt : m_pc + 16'd3; m_len = 6; m_req = "R10"; end
                8'h07: begin m_pc = !m_z ? tgt : m_pc + 16'd3; m_len = 6; m_req = "R10"; end
                8'h08: begin m_ac = m_ac + m_r; m_z = (m_ac == 0); m_pc = m_pc + 16'd1; m_req = "R6"; end
                8'h09: begin m_ac = m_ac - m_r; m_z = (m_ac == 0); m_pc = m_pc + 16'd1; m_req = "R6"; end
                8'h0A: begin m_ac = m_ac + 8'd1; m_z = (m_ac == 0); m_pc = m_pc + 16'd1; m_req = "R6"; end
                8'h0B: begin m_ac = 8'h00; m_z = 1'b1; m_pc = m_pc + 16'd1; m_req = "R8"; end
                8'h0C: begin m_ac = m_ac & m_r; m_z = (m_ac == 0); m_pc = m_pc + 16'd1; m_req = "R7"; end
                8'h0D: begin m_ac = m_ac | m_r; m_z = (m_ac == 0); m_pc = m_pc + 16'd1; m_req = "R7"; end
                8'h0E: begin m_ac = m_ac ^ m_r; m_z = (m_ac == 0); m_pc = m_pc + 16'd1; m_req = "R7"; end
                8'h0F: begin m_ac = ~m_ac; m_z = (m_ac == 0); m_pc = m_pc + 16'd1; m_req = "R7"; end
                default: begin m_pc = m_pc + 16'd1; m_req = "R11"; end
            endcase
        end
        // write strobe appears only in the seventh cycle of STAC (R4)
        check("R4", {31'h0, mem_we}, {31'h0, (m_op == 8'h02) && (m_off == 6)});
        if (mem_we) begin
            check("R4", {16'h0, mem_addr}, {16'h0, m_wa});
            check("R4", {24'h0, mem_wdata}, {24'h0, m_wd});
        end
        m_off++;
        if (m_off == m_len) m_off = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        // R1: cleared state during reset
        check("R1", {16'h0, dbg_pc}, 32'h0);
        check("R1", {24'h0, dbg_ac}, 32'h0);
        check("R1", {24'h0, dbg_r}, 32'h0);
        check("R1", {31'h0, dbg_z}, 32'h0);
        check("R1", {31'h0, mem_we}, 32'h0);
        rst   = 1'b0;
        m_pc  = 16'h0; m_ac = 8'h0; m_r = 8'h0; m_z = 1'b0;
        m_off = 0; m_len = 2; m_op = 8'h00; m_req = "R1";
    endtask

    task automatic run(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            model_step();
            @(negedge clk);
        end
    endtask

    initial begin
        #1_500_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // Program A: every opcode, both polarities of each conditional jump
        clear_mem();
        mem[12'h050] = 8'h37;
        wp = 12'h000;
        emit(8'h0B);                              // CLAC, Z=1
        emit(8'h06); emit(8'h10); emit(8'h00);    // JMPZ 0010h taken
        emit(8'h0F);                              // skipped
        wp = 12'h010;
        emit(8'h0A);                              // INAC -> 01
        emit(8'h06); emit(8'h00); emit(8'h03);    // JMPZ not taken
        emit(8'h07); emit(8'h20); emit(8'h00);    // JPNZ 0020h taken
        wp = 12'h020;
        emit(8'h0F);                              // NOT -> FE
        emit(8'h03);                              // MVAC
        emit(8'h0A); emit(8'h0A);                 // FF, then wrap to 00 with Z=1
        emit(8'h07); emit(8'h00); emit(8'h03);    // JPNZ not taken
        emit(8'h04);                              // MOVR, Z stays 1
        emit(8'h08); emit(8'h09); emit(8'h0E);    // ADD SUB XOR
        emit(8'h0D); emit(8'h0C);                 // OR AND
        emit(8'h02); emit(8'h00); emit(8'h08);    // STAC 0800h
        emit(8'h0B);                              // CLAC
        emit(8'h01); emit(8'h00); emit(8'h08);    // LDAC 0800h, Z stays 1
        emit(8'h10); emit(8'hFF); emit(8'h00);    // undefined and NOP opcodes
        emit(8'h01); emit(8'h50); emit(8'h00);    // LDAC 0050h
        emit(8'h03); emit(8'h09);                 // MVAC, SUB -> 0
        emit(8'h05); emit(8'h34); emit(8'h12);    // JUMP 1234h
        wp = 12'h234;
        emit(8'h0A);                              // INAC
        emit(8'h05); emit(8'h34); emit(8'h12);    // loop
        do_reset();
        run(320);
        check("R4", {24'h0, mem[12'h800]}, 32'hFE);  // stored NOT/AND result
        // R1: reset in the middle of execution
        do_reset();
        run(40);

        // Program B: sum of 1..5 with loop exit through an untaken JPNZ
        clear_mem();
        mem[12'h0F0] = 8'd5;
        wp = 12'h000;
        emit(8'h05); emit(8'h00); emit(8'h01);    // JUMP 0100h
        wp = 12'h100;
        emit(8'h0B);
        emit(8'h02); emit(8'hF1); emit(8'h00);
        emit(8'h02); emit(8'hF2); emit(8'h00);
        emit(8'h01); emit(8'hF2); emit(8'h00);    // loop at 0107h
        emit(8'h0A);
        emit(8'h02); emit(8'hF2); emit(8'h00);
        emit(8'h03);
        emit(8'h01); emit(8'hF1); emit(8'h00);
        emit(8'h08);
        emit(8'h02); emit(8'hF1); emit(8'h00);
        emit(8'h01); emit(8'hF0); emit(8'h00);
        emit(8'h09);
        emit(8'h07); emit(8'h07); emit(8'h01);    // JPNZ loop
        emit(8'h05); emit(8'h1D); emit(8'h01);    // park
        do_reset();
        run(420);
        check("R10", {24'h0, mem[12'h0F1]}, 32'd15);
        check("R10", {16'h0, dbg_pc[15:0]}, 32'h011D);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule